// File: doc/BRIEF.md
# Stateful Tie-Breaking Rounding Unit

This block narrows a fixed-point sample by removing its `DROP_W` least significant bits, leaving a result `IN_W - DROP_W` bits wide. Values that are not exactly half-way between two output steps round to the nearer step. Exact half-way values ("ties") are resolved by a selectable policy that keeps state between samples. The choices are a flip-flop that alternates up and down on successive ties, or a pseudo-random bit. A third, stochastic policy applies to every sample and rounds up with a probability equal to the discarded fraction. Both tie policies remove the DC offset of half-up rounding, and they avoid the magnitude bias of half-away-from-zero rounding.

A build parameter selects signed (two's complement) or unsigned data. A per-sample clip enable saturates a result that would overflow instead of letting it wrap. The output is registered with one cycle of latency, and samples are qualified by a valid strobe. The alternation state and the pseudo-random generator move only on valid samples, so the sequence of decisions depends on the data stream and not on idle time.

Top module: `tie_round_unit`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. `out_data` takes the result of a valid sample one clock after that sample and holds its value while `in_valid` is low. In reset, `out_valid` and `out_data` are 0.
- R2: Let the fraction be the dropped bits `in_data[DROP_W-1:0]`, and let half be 2**(DROP_W-1). With mode 00, 01 or 11, a fraction below half gives the floor `in_data[IN_W-1:DROP_W]`, and a fraction above half gives floor+1. A zero fraction gives the floor in every mode.
- R3: A tie is a fraction equal to half. Mode 00, and mode 11 which acts the same, resolves ties alternately up (floor+1) and down (floor). The first tie after reset goes up. The selector flips only on a valid tie in these modes.
- R4: Mode 01 resolves a tie up when bit 15 of the generator state is 1 and down when it is 0, using the state present in the clock the sample is accepted.
- R5: The generator is a 16-bit shift-left register that shifts in the XOR of its bits 15, 14, 12 and 3. It resets to 0xACE1, advances one step on every valid sample in all modes, holds otherwise, and never reaches zero.
- R6: Mode 10 rounds any sample up exactly when its fraction is greater than generator bits [15:13] read as unsigned. A constant fraction of 2/8 therefore rounds up in about a quarter of samples.
- R7: For signed data, a tie at a negative value uses the same selector as a positive tie. For example, -2.5 gives -2 when the choice is up and -3 when it is down.
- R8: With `clip_en` = 1, a result that would exceed the largest output code is held at that code: 2**(OUT_W-1)-1 for signed data and all ones for unsigned data.
- R9: With `clip_en` = 0, such an overflow wraps: to the most negative code for signed data and to 0 for unsigned data.
- R10: With `DROP_W` = 0, `out_data` is the valid input sample delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Input sample, signed or unsigned by parameter |
| mode | input | 2 | Policy: 00 alternate, 01 random tie, 10 stochastic, 11 alternate |
| clip_en | input | 1 | Saturate instead of wrap on overflow |
| out_valid | output | 1 | Output qualifier, one clock after `in_valid` |
| out_data | output | IN_W-DROP_W | Rounded result |

## Verification
Tie resolution and overflow handling meet when a tie sits just below the largest code. An example is signed 15.5 with a 5-bit output: an up decision pushes it past the maximum. The bench sends such samples while the alternation selector points up and while it points down, with clip on and off. It checks that the selector still flips and that the result is the clipped maximum, the wrapped minimum, or the plain floor, as the requirements say. Every mode and clip setting also sweeps all 256 input codes, with idle gaps, so generator advancement and tie decisions fall together with idle cycles.

// File: rtl/tru_pkg.sv
package tru_pkg;
  typedef enum logic [1:0] {
    TRU_ALT   = 2'b00,
    TRU_RAND  = 2'b01,
    TRU_STOCH = 2'b10,
    TRU_ALT_B = 2'b11
  } tru_mode_e;
endpackage

// File: rtl/tru_lfsr.sv
// Fibonacci shift register, advances one step when adv is high.
module tru_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hD008,
  parameter logic [W-1:0]   SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  always_comb begin
    st_d = st_q;
    if (adv) begin
      st_d = {st_q[W-2:0], ^(st_q & TAPS)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else begin
      st_q <= st_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/tru_alt_toggle.sv
// Up/down selector for alternating tie resolution; starts at "up".
module tru_alt_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic consume,
  output logic up
);
  logic up_q;
  logic up_d;

  always_comb begin
    up_d = up_q;
    if (consume) begin
      up_d = ~up_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b1;
    end else begin
      up_q <= up_d;
    end
  end

  assign up = up_q;
endmodule

// File: rtl/tru_round_core.sv
// Combinational rounder: floor plus a round-up decision, with optional clip.
module tru_round_core
  import tru_pkg::*;
#(
  parameter int IN_W        = 8,
  parameter int DROP_W      = 3,
  parameter bit SIGNED_DATA = 1'b1
) (
  input  logic [IN_W-1:0]        in_data,
  input  tru_mode_e              mode_e,
  input  logic                   clip_en,
  input  logic                   alt_up,
  input  logic [DROP_W-1:0]      lfsr_top,
  input  logic                   lfsr_msb,
  output logic [IN_W-DROP_W-1:0] res,
  output logic                   tie
);
  localparam int                OUT_W = IN_W - DROP_W;
  localparam logic [DROP_W-1:0] HALF  = DROP_W'(1 << (DROP_W - 1));
  localparam logic [OUT_W-1:0]  ALL1  = '1;
  localparam logic [OUT_W-1:0]  MAXV  = SIGNED_DATA ? (ALL1 >> 1) : ALL1;

  logic [DROP_W-1:0] frac;
  logic [OUT_W-1:0]  base;
  logic              up;
  logic [OUT_W:0]    sum;
  logic              ovf;

  assign frac = in_data[DROP_W-1:0];
  assign base = in_data[IN_W-1:DROP_W];
  assign tie  = (frac == HALF);

  always_comb begin
    unique case (mode_e)
      TRU_STOCH: up = (frac > lfsr_top);
      TRU_RAND:  up = (frac > HALF) || (tie && lfsr_msb);
      default:   up = (frac > HALF) || (tie && alt_up);
    endcase
  end

  assign sum = {1'b0, base} + {{OUT_W{1'b0}}, up};

  generate
    if (SIGNED_DATA) begin : g_sovf
      assign ovf = up && (base == MAXV);
    end else begin : g_uovf
      assign ovf = sum[OUT_W];
    end
  endgenerate

  always_comb begin
    res = sum[OUT_W-1:0];
    if (ovf && clip_en) begin
      res = MAXV;
    end
  end
endmodule

// File: rtl/tie_round_unit.sv
module tie_round_unit
  import tru_pkg::*;
#(
  parameter int              IN_W        = 8,
  parameter int              DROP_W      = 3,
  parameter bit              SIGNED_DATA = 1'b1,
  parameter int              LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [IN_W-1:0]        in_data,
  input  logic [1:0]             mode,
  input  logic                   clip_en,
  output logic                   out_valid,
  output logic [IN_W-DROP_W-1:0] out_data
);
  localparam int OUT_W = IN_W - DROP_W;

  tru_mode_e         mode_e;
  logic              alt_up;
  logic [LFSR_W-1:0] lfsr_state;
  logic [OUT_W-1:0]  res;
  logic              tie;
  logic              alt_consume;
  logic              ov_q, ov_d;
  logic [OUT_W-1:0]  od_q, od_d;

  assign mode_e      = tru_mode_e'(mode);
  assign alt_consume = in_valid && tie && (mode_e == TRU_ALT || mode_e == TRU_ALT_B);

  tru_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (in_valid),
    .state (lfsr_state)
  );

  tru_alt_toggle u_alt (
    .clk     (clk),
    .rst_n   (rst_n),
    .consume (alt_consume),
    .up      (alt_up)
  );

  generate
    if (DROP_W == 0) begin : g_pass
      assign res = in_data;
      assign tie = 1'b0;
    end else begin : g_round
      tru_round_core #(
        .IN_W        (IN_W),
        .DROP_W      (DROP_W),
        .SIGNED_DATA (SIGNED_DATA)
      ) u_core (
        .in_data  (in_data),
        .mode_e   (mode_e),
        .clip_en  (clip_en),
        .alt_up   (alt_up),
        .lfsr_top (lfsr_state[LFSR_W-1 -: DROP_W]),
        .lfsr_msb (lfsr_state[LFSR_W-1]),
        .res      (res),
        .tie      (tie)
      );
    end
  endgenerate

  always_comb begin
    ov_d = in_valid;
    od_d = od_q;
    if (in_valid) begin
      od_d = res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= ov_d;
      od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/tru_checker.sv
module tru_checker #(
  parameter int IN_W        = 8,
  parameter int DROP_W      = 3,
  parameter bit SIGNED_DATA = 1'b1,
  parameter int LFSR_W      = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [IN_W-1:0]        in_data,
  input logic [1:0]             mode,
  input logic                   clip_en,
  input logic                   out_valid,
  input logic [IN_W-DROP_W-1:0] out_data,
  input logic                   alt_up,
  input logic [LFSR_W-1:0]      lfsr_state
);
  localparam int               OUT_W = IN_W - DROP_W;
  localparam logic [OUT_W-1:0] ALL1  = '1;
  localparam logic [OUT_W-1:0] MAXV  = SIGNED_DATA ? (ALL1 >> 1) : ALL1;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R1
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0); // R5
  AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lfsr_state)); // R5

  generate
    if (DROP_W > 0) begin : g_rnd
      localparam logic [DROP_W-1:0] HALF = DROP_W'(1 << (DROP_W - 1));
      logic alt_tie;
      assign alt_tie = in_valid && (in_data[DROP_W-1:0] == HALF) && (mode[1] == mode[0]);

      AST_EXACT_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[DROP_W-1:0] == '0) |=> out_data == $past(in_data[IN_W-1:DROP_W])); // R2
      AST_ALT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        alt_tie |=> alt_up != $past(alt_up)); // R3
      AST_ALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_tie |=> $stable(alt_up)); // R3
      AST_CLIP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clip_en && in_data[IN_W-1:DROP_W] == MAXV) |=> out_data == MAXV); // R8
    end else begin : g_pass
      AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_data == $past(in_data)); // R10
    end
  endgenerate
endmodule

bind tie_round_unit tru_checker #(
  .IN_W        (IN_W),
  .DROP_W      (DROP_W),
  .SIGNED_DATA (SIGNED_DATA),
  .LFSR_W      (LFSR_W)
) u_tru_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .mode       (mode),
  .clip_en    (clip_en),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .alt_up     (alt_up),
  .lfsr_state (lfsr_state)
);

// File: tb/tie_round_unit_bench.sv
`timescale 1ns/1ps
module tie_round_unit_bench;
  localparam int IN_W   = 8;
  localparam int DROP_W = 3;
  localparam int OUT_W  = IN_W - DROP_W;
  localparam int FMASK  = (1 << DROP_W) - 1;
  localparam int HALF   = 1 << (DROP_W - 1);
  localparam int OMASK  = (1 << OUT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic [1:0]       mode = 2'b00;
  logic             clip_en = 1'b0;
  logic             ov_s, ov_u, ov_p;
  logic [OUT_W-1:0] od_s, od_u;
  logic [IN_W-1:0]  od_p;

  tie_round_unit #(.IN_W(IN_W), .DROP_W(DROP_W), .SIGNED_DATA(1'b1)) u_tie_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
    .clip_en(clip_en), .out_valid(ov_s), .out_data(od_s));
  tie_round_unit #(.IN_W(IN_W), .DROP_W(DROP_W), .SIGNED_DATA(1'b0)) u_tie_round_unit_uns (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
    .clip_en(clip_en), .out_valid(ov_u), .out_data(od_u));
  tie_round_unit #(.IN_W(IN_W), .DROP_W(0), .SIGNED_DATA(1'b1)) u_tie_round_unit_pass (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
    .clip_en(clip_en), .out_valid(ov_p), .out_data(od_p));

  int checks = 0;
  int errors = 0;
  int stoch_up = 0;
  string cur_tag = "R2";
  string exp_tag = "R2";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_round(int raw, bit sgn, int md, bit clp, int alt, int lf);
    int val, frac, base, up, r, maxv, minv;
    frac = raw & FMASK;
    val  = (sgn && raw >= (1 << (IN_W - 1))) ? raw - (1 << IN_W) : raw;
    base = (val - frac) / (1 << DROP_W);
    if (md == 2)      up = (frac > ((lf >> (16 - DROP_W)) & FMASK)) ? 1 : 0;
    else if (md == 1) up = (frac > HALF || (frac == HALF && ((lf >> 15) & 1) == 1)) ? 1 : 0;
    else              up = (frac > HALF || (frac == HALF && alt == 1)) ? 1 : 0;
    r    = base + up;
    maxv = sgn ? (1 << (OUT_W - 1)) - 1 : OMASK;
    minv = sgn ? -(1 << (OUT_W - 1)) : 0;
    if (r > maxv) r = clp ? maxv : minv;
    return r & OMASK;
  endfunction

  // Behavioural reference: tie selector, generator and expected outputs.
  int alt_m, lfsr_m, exp_s, exp_u, exp_p;
  bit exp_v;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_m = 1; lfsr_m = 'hACE1; exp_v = 0; exp_s = 0; exp_u = 0; exp_p = 0;
    end else begin
      exp_v   = in_valid;
      exp_tag = cur_tag;
      if (in_valid) begin
        exp_s = ref_round(int'(in_data), 1'b1, int'(mode), clip_en, alt_m, lfsr_m);
        exp_u = ref_round(int'(in_data), 1'b0, int'(mode), clip_en, alt_m, lfsr_m);
        exp_p = int'(in_data);
        if ((mode == 2'b00 || mode == 2'b11) && (int'(in_data) & FMASK) == HALF) alt_m = 1 - alt_m;
        lfsr_m = ((lfsr_m << 1) | ($countones(lfsr_m & 'hD008) & 1)) & 'hFFFF;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "signed out_valid", 32'(ov_s), 32'(exp_v));
      chk("R1", "unsigned out_valid", 32'(ov_u), 32'(exp_v));
      chk(exp_tag, "signed out_data", 32'(od_s), 32'(exp_s));
      chk(exp_tag, "unsigned out_data", 32'(od_u), 32'(exp_u));
      chk("R10", "pass out_data", 32'(od_p), 32'(exp_p));
      if (exp_tag == "R6" && exp_v && od_s == 5'd3) stoch_up++;
    end
  end

  task automatic send(input int d, input int md, input bit clp);
    @(negedge clk);
    in_valid = 1'b1; in_data = IN_W'(d); mode = 2'(md); clip_en = clp;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic look(input string req, input int es, input int eu);
    @(posedge clk); #1;
    chk(req, "signed literal", 32'(od_s), 32'(es));
    chk(req, "unsigned literal", 32'(od_u), 32'(eu));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); #1;
    chk("R1", "reset valid", 32'(ov_s | ov_u | ov_p), 32'd0);
    chk("R1", "reset data", 32'(od_s | od_u), 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    idle(2);

    // Alternating ties, positive and negative (R3, R7), fresh selector.
    cur_tag = "R3";
    send('h14, 0, 1'b0); look("R3", 3, 3);
    send('h14, 0, 1'b0); look("R3", 2, 2);
    cur_tag = "R7";
    send('hEC, 0, 1'b0); look("R7", 30, 30);
    send('hEC, 0, 1'b0); look("R7", 29, 29);
    idle(3);

    // Tie at the top code with clip, then overflow without clip (R8, R9).
    cur_tag = "R8";
    send('h7C, 0, 1'b1); look("R8", 15, 16);
    send('h7D, 0, 1'b1); look("R8", 15, 16);
    cur_tag = "R9";
    send('h7D, 0, 1'b0); look("R9", 16, 16);
    cur_tag = "R8";
    send('hFD, 0, 1'b1); look("R8", 0, 31);
    cur_tag = "R9";
    send('hFD, 0, 1'b0); look("R9", 0, 0);
    cur_tag = "R10";
    send('hA5, 0, 1'b0); @(posedge clk); #1; chk("R10", "pass literal", 32'(od_p), 32'hA5);
    idle(2);

    // Constant fraction 2/8 in stochastic mode (R6).
    cur_tag = "R6";
    for (int i = 0; i < 512; i++) send('h12, 2, 1'b0);
    idle(2);
    checks++;
    if (stoch_up < 96 || stoch_up > 160) begin
      errors++;
      $display("FAIL R6 round-up count: actual %0d expected 96..160", stoch_up);
    end

    // Full sweeps in every mode and clip setting, idle gaps stall the state (R2, R4, R5).
    for (int md = 0; md < 4; md++) begin
      for (int c = 0; c < 2; c++) begin
        cur_tag = (md == 1) ? "R4" : (md == 2) ? "R6" : (md == 3) ? "R3" : "R2";
        for (int v = 0; v < 256; v++) begin
          if (v % 7 == 3) begin
            cur_tag = "R5"; idle(1);
            cur_tag = (md == 1) ? "R4" : (md == 2) ? "R6" : (md == 3) ? "R3" : "R2";
          end
          send(v, md, c[0]);
        end
      end
    end
    idle(3);

    // Reset mid-stream restores selector and generator (R1, R5).
    do_reset();
    cur_tag = "R5";
    for (int i = 0; i < 20; i++) send('h0C, 1, 1'b0);
    idle(3);
    finish_run();
  end
endmodule